// File: doc/BRIEF.md
# Status-Change Alert Generator

This block lets a host avoid polling a set of status bytes. It keeps a copy of five status bytes that a sensing core refreshes through per-byte update strobes. When a refresh brings a value that differs from the stored copy, the byte is marked pending. While any byte is pending, the block pulls an open-drain alert line low. The bus interface reports every host read as a read pulse with a register address. The status bytes sit at register addresses 2 to 6, so byte i is at address 2+i. A read of a pending byte clears that byte's mark. The line is released only when every byte that changed has been read.

A two-state machine drives the line. In state QUIET the line is released. In state ALERT it is pulled low. Transition RAISE goes from QUIET to ALERT when any pending mark is set. Transition RELEASE goes from ALERT to QUIET when no mark is set. Otherwise the state holds. The line output comes straight from the state register, so it cannot glitch. The stored bytes are also brought out so that the bus interface can return them on reads.

Top module: `stat_alert_top`

## Requirements
- R1: After reset, every stored byte is 0x00, every pending mark is 0, and `alert_pull_low` is 0 (line released).
- R2: A strobe on byte i whose data differs from the stored byte sets pending mark i at the sampling edge. `alert_pull_low` goes to 1 one edge after that.
- R3: A strobe whose data equals the stored byte leaves that byte's pending mark unchanged.
- R4: A read pulse with `rd_addr` equal to 2+i clears pending mark i at the sampling edge and leaves the other marks unchanged.
- R5: A read of any address outside 2..6, or an address presented while `rd_valid` is 0, changes no pending mark.
- R6: `alert_pull_low` equals the OR of the pending marks as they stood one edge earlier. It therefore stays at 1 until every changed byte has been read.
- R7: When a differing strobe and a read of the same byte fall in the same cycle, the pending mark ends up set.
- R8: Every strobe loads its data into the stored byte. The new value appears on `stat_value` after the sampling edge, whether the data changed or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 5 | Per-byte update strobes from the sensing core |
| upd_data | input | 40 | New byte values; byte i in bits [8i+7:8i] |
| rd_valid | input | 1 | Host read pulse from the bus interface |
| rd_addr | input | 8 | Register address of the host read |
| stat_value | output | 40 | Stored status bytes, same layout as `upd_data` |
| pend_q | output | 5 | Pending mark per byte |
| alert_pull_low | output | 1 | 1 engages the pull-down on the open-drain alert pin; 0 releases it |

## Verification
Stored values and pending marks are due one edge after the strobe or read that causes them. The alert line is due one edge later than the marks. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares the marks and values to the new model at the next falling edge. It compares the line to the OR of the marks the model held before that rising edge, so each result is checked in the cycle it is due.

// File: rtl/stat_alert_pkg.sv
package stat_alert_pkg;
    // Alert line states: QUIET releases the pin, ALERT pulls it low.
    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } alert_st_e;
endpackage

// File: rtl/stat_slot.sv
module stat_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_val,
    input  logic              rd_hit,
    output logic [DATA_W-1:0] value_q,
    output logic              pend_q
);
    logic changed;

    assign changed = upd_en && (upd_val != value_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (upd_en) begin
                value_q <= upd_val;
            end
            // A fresh change outranks a read in the same cycle.
            if (changed) begin
                pend_q <= 1'b1;
            end else if (rd_hit) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R7
    change_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (upd_val != value_q) && rd_hit) |=> pend_q);

    // R3
    same_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (upd_val == value_q) && !rd_hit) |=> $stable(pend_q));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !(upd_en && (upd_val != value_q))) |=> !pend_q);

    // R8
    value_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (value_q == $past(upd_val)));
endmodule

// File: rtl/alert_fsm.sv
module alert_fsm
    import stat_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic alert_pull_low
);
    alert_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (any_pend)  state_d = ST_ALERT;   // RAISE
            ST_ALERT: if (!any_pend) state_d = ST_QUIET;   // RELEASE
            default:  state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        alert_pull_low = (state_q == ST_ALERT);
    end

    // R6
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> alert_pull_low);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !alert_pull_low);
endmodule

// File: rtl/stat_alert_top.sv
module stat_alert_top #(
    parameter int NUM_STAT  = 5,
    parameter int BASE_ADDR = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_STAT-1:0]        upd_en,
    input  logic [NUM_STAT*DATA_W-1:0] upd_data,
    input  logic                       rd_valid,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [NUM_STAT*DATA_W-1:0] stat_value,
    output logic [NUM_STAT-1:0]        pend_q,
    output logic                       alert_pull_low
);
    logic [NUM_STAT-1:0] rd_hit;

    for (genvar g = 0; g < NUM_STAT; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + g);

        assign rd_hit[g] = rd_valid && (rd_addr == SLOT_ADDR);

        stat_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_en[g]),
            .upd_val (upd_data[g*DATA_W +: DATA_W]),
            .rd_hit  (rd_hit[g]),
            .value_q (stat_value[g*DATA_W +: DATA_W]),
            .pend_q  (pend_q[g])
        );
    end

    alert_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .any_pend       (|pend_q),
        .alert_pull_low (alert_pull_low)
    );

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && (upd_en == '0)) |=> $stable(pend_q));
endmodule

// File: tb/sim_stat_alert_top.sv
module sim_stat_alert_top;
    localparam int N = 5;
    localparam int W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     upd_en = '0;
    logic [N*W-1:0]   upd_data = '0;
    logic             rd_valid = 1'b0;
    logic [7:0]       rd_addr = '0;
    logic [N*W-1:0]   stat_value;
    logic [N-1:0]     pend_q;
    logic             alert_pull_low;

    int vecs = 0;
    int fails = 0;

    logic [W-1:0] mval [N];
    logic [N-1:0] mpend;
    logic         malert;

    always #10 clk = ~clk;

    stat_alert_top u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_data(upd_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .stat_value(stat_value),
        .pend_q(pend_q), .alert_pull_low(alert_pull_low)
    );

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [N*W-1:0] ev;
        for (int i = 0; i < N; i++) ev[i*W +: W] = mval[i];
        check_eq({tag, " pending"}, 64'(pend_q), 64'(mpend));
        check_eq("R8 stored value", 64'(stat_value), 64'(ev));
        check_eq("R6 alert line", 64'(alert_pull_low), 64'(malert));
    endtask

    // Apply one cycle of stimulus (called at a falling edge), model it, check.
    task automatic step(logic [N-1:0] en, logic [N*W-1:0] d,
                        logic rv, logic [7:0] ra, string tag);
        upd_en = en; upd_data = d; rd_valid = rv; rd_addr = ra;
        @(posedge clk);
        malert = |mpend;
        for (int i = 0; i < N; i++) begin
            logic chg, hit;
            chg = en[i] && (d[i*W +: W] != mval[i]);
            hit = rv && (ra == 8'(2 + i));
            if (chg) mpend[i] = 1'b1;
            else if (hit) mpend[i] = 1'b0;
            if (en[i]) mval[i] = d[i*W +: W];
        end
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic logic [N*W-1:0] put(int i, logic [W-1:0] v);
        logic [N*W-1:0] r;
        for (int k = 0; k < N; k++) r[k*W +: W] = mval[k];
        r[i*W +: W] = v;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mval[i] = '0;
        mpend = '0;
        malert = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R3: identical value after reset
        step(5'b00001, put(0, 8'h00), 1'b0, 8'd0, "R3 same value");
        // R2: differing value on byte 1
        step(5'b00010, put(1, 8'h5A), 1'b0, 8'd0, "R2 change");
        step(5'b00000, '0, 1'b0, 8'd0, "R2 alert raise");
        // R5: stray and invalid reads
        step(5'b00000, '0, 1'b1, 8'd1, "R5 addr 1");
        step(5'b00000, '0, 1'b1, 8'd7, "R5 addr 7");
        step(5'b00000, '0, 1'b1, 8'hFF, "R5 addr FF");
        step(5'b00000, '0, 1'b0, 8'd3, "R5 no valid");
        // R7: change and read of byte 1 together
        step(5'b00010, put(1, 8'hA5), 1'b1, 8'd3, "R7 change wins");
        // R4: byte 3 changes, then read byte 1 only
        step(5'b01000, put(3, 8'h11), 1'b0, 8'd0, "R2 change byte3");
        step(5'b00000, '0, 1'b1, 8'd3, "R4 read byte1");
        step(5'b00000, '0, 1'b0, 8'd0, "R6 still held");
        step(5'b00000, '0, 1'b1, 8'd5, "R4 read byte3");
        step(5'b00000, '0, 1'b0, 8'd0, "R6 release");

        // Near-exhaustive sweep: all strobe masks, read addresses 0..8, data picks
        for (int m = 0; m < 32; m++) begin
            for (int a = 0; a < 9; a++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [N*W-1:0] d;
                    for (int i = 0; i < N; i++) begin
                        if (((m + a + s + i) & 1) == 1)
                            d[i*W +: W] = mval[i];
                        else
                            d[i*W +: W] = mval[i] ^ 8'(i + 1 + s);
                    end
                    step(5'(m), d, (s != 3), 8'(a), "R4 R5 R7 sweep");
                end
            end
        end
        for (int a = 2; a < 7; a++) step('0, '0, 1'b1, 8'(a), "R4 drain");
        step('0, '0, 1'b0, 8'd0, "R6 final release");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule